// File: doc/BRIEF.md
# Sub-Band Sample Delay Port

This block sits on a serial audio link that carries 24-bit sub-band samples. It takes each stereo sample pair from one data pin, holds it for a fixed number of word periods, and then sends it out on the other data pin. The delay keeps the samples aligned with results that another unit produces in parallel. Everything runs on the link's bit clock, which makes 64 cycles per word-select period. Incoming bits are sampled on the rising edge of the bit clock. Outgoing bits change on the falling edge.

A direction input selects which pin receives and which pin transmits. It also selects the delay length. The block reads the direction only while reset is held, so the chosen role stays fixed until the next reset. After reset ends, both output enables stay off for a short guard interval. Then only the transmitting pin is enabled.

A frame-sync input marks the word period that carries sub-band 0. From that point a sub-band index and a valid flag are provided for monitoring.

Top module: `sbd_delay_port`

## Requirements
- R1: A word period is 64 bit-clock cycles and starts when word select falls. Call the cycle in which word select has just changed slot 0. The half with word select low carries the left sample and the half with word select high carries the right sample. In each half, the 24 sample bits occupy slots 1 to 24 with the MSB in slot 1. Slot 0 and slots 25 to 31 carry zero on the transmitting pin.
- R2: With direction low (encode), samples are taken from pin A and the pair received in word period q appears on pin B in word period q+480.
- R3: With direction high (decode), samples are taken from pin B and the pair received in word period q appears on pin A in word period q+160.
- R4: Every output word period earlier than the delay, counted from the first word start after reset, carries all zeros. This holds even when the store still has data from before the reset.
- R5: Direction is the value held on the input while reset is high, as seen at reset release. Later changes of the direction input have no effect. The non-receiving pin's input is ignored, and the non-transmitting pin is never driven or enabled.
- R6: Both output enables are low during reset and for the first 2 word periods after reset. From slot 1 of word period 2 onward, the transmitting pin's enable stays high. Data on a pin is zero whenever its enable is low.
- R7: The sub-band valid flag is low until frame sync is seen high at a word start. In that word period the index is 0, and it rises by one in each following word period, wrapping from 31 to 0. A later frame sync resets the index to 0.
- R8: During reset, both data outputs, both enables and the sub-band valid flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 64 cycles per word period |
| rst | input | 1 | Synchronous active-high reset; direction is captured while high |
| dir | input | 1 | 0 = encode (A to B), 1 = decode (B to A) |
| ws | input | 1 | Word select: low = left half, high = right half |
| fsync | input | 1 | High during the word period carrying sub-band 0 |
| a_in | input | 1 | Pin A receive data |
| b_in | input | 1 | Pin B receive data |
| a_out | output | 1 | Pin A transmit data |
| a_oe | output | 1 | Pin A output enable |
| b_out | output | 1 | Pin B transmit data |
| b_oe | output | 1 | Pin B output enable |
| sb_idx | output | 5 | Sub-band index of the current word period |
| sb_valid | output | 1 | Sub-band index is meaningful |

## Verification
A slot counter that is off by one shifts every replayed sample by one bit, and a bad halves decode swaps left and right. Either shows as a wrong word in the first period that carries data, at period 480 or 160. A read pointer or delay error shows as a wrong word in that same first replayed period. A fill flag that asserts too early puts nonzero data out before that period, and one that stays low keeps the output at zero past it. Enable, direction and sub-band errors are visible within a single word period after reset or after the sync period.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

  typedef enum logic {
    DIR_ENCODE = 1'b0,
    DIR_DECODE = 1'b1
  } dir_e;

  function automatic int max_int(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sbd_frame_rx.sv
// Tracks slot position from word select, deserialises the stereo pair,
// and keeps the sub-band index.
module sbd_frame_rx #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 6,
  parameter int SB_W     = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ws,
  input  logic                  din,
  input  logic                  fsync,
  output logic                  frame_start,
  output logic                  word_stb,
  output logic [2*SAMPLE_W-1:0] word,
  output logic [SLOT_W-1:0]     next_slot,
  output logic                  next_right,
  output logic [SB_W-1:0]       sb_idx,
  output logic                  sb_valid
);

  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

  logic                ws_q;
  logic                ws_edge;
  logic [SLOT_W-1:0]   slot;
  logic [SLOT_W-1:0]   cnt_q;
  logic [SAMPLE_W-1:0] shreg;
  logic [SAMPLE_W-1:0] left_q;
  logic                started;
  logic                take;

  always_ff @(posedge clk) ws_q <= ws;

  assign ws_edge     = ws ^ ws_q;
  assign frame_start = ws_edge & ~ws;
  assign slot        = ws_edge ? '0 : cnt_q;
  assign take        = (slot >= SLOT_W'(1)) && (slot <= SLOT_W'(SAMPLE_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      started <= 1'b0;
    end else begin
      cnt_q <= (slot == SLOT_MAX) ? slot : slot + 1'b1;
      if (frame_start) started <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take) shreg <= {shreg[SAMPLE_W-2:0], din};
    if (ws_edge && ws) left_q <= shreg;
  end

  assign word_stb   = frame_start & started;
  assign word       = {left_q, shreg};
  assign next_slot  = cnt_q;
  assign next_right = ws_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sb_idx   <= '0;
      sb_valid <= 1'b0;
    end else if (frame_start) begin
      if (fsync) begin
        sb_idx   <= '0;
        sb_valid <= 1'b1;
      end else if (sb_valid) begin
        sb_idx <= sb_idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sbd_ring.sv
// Circular store of stereo words; the read address trails the write
// pointer by the delay of the selected direction.
module sbd_ring import sbd_pkg::*; #(
  parameter int WORD_W    = 48,
  parameter int ENC_DELAY = 480,
  parameter int DEC_DELAY = 160
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              decode,
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] rd_word,
  output logic              filled
);

  localparam int MAX_D = max_int(ENC_DELAY, DEC_DELAY);
  localparam int AW    = $clog2(MAX_D);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(MAX_D + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp;
  logic [AW-1:0]     rd_addr;
  logic [CW-1:0]     wcount;
  logic [CW-1:0]     limit;

  assign rd_addr = wp - (decode ? AW'(DEC_DELAY - 1) : AW'(ENC_DELAY - 1));
  assign limit   = decode ? CW'(DEC_DELAY - 1) : CW'(ENC_DELAY - 1);

  always_ff @(posedge clk) begin
    if (wr_stb) begin
      mem[wp] <= wr_word;
      rd_word <= mem[rd_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      wcount <= '0;
      filled <= 1'b0;
    end else if (wr_stb) begin
      wp     <= wp + 1'b1;
      filled <= (wcount >= limit);
      if (wcount != limit) wcount <= wcount + 1'b1;
    end
  end

endmodule

// File: rtl/sbd_tx.sv
// Serialises the delayed word onto the transmitting pin on the falling edge.
module sbd_tx #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  decode,
  input  logic                  active,
  input  logic                  filled,
  input  logic [2*SAMPLE_W-1:0] word,
  input  logic [SLOT_W-1:0]     next_slot,
  input  logic                  next_right,
  output logic                  a_out,
  output logic                  b_out
);

  localparam int IDX_W = $clog2(SAMPLE_W);

  logic [SAMPLE_W-1:0] sample;
  logic [IDX_W-1:0]    pos;
  logic                in_range;
  logic                drive;

  assign sample   = next_right ? word[SAMPLE_W-1:0] : word[2*SAMPLE_W-1:SAMPLE_W];
  assign pos      = IDX_W'(SAMPLE_W - 1) - IDX_W'(next_slot - 1'b1);
  assign in_range = (next_slot >= SLOT_W'(1)) && (next_slot <= SLOT_W'(SAMPLE_W));
  assign drive    = active & filled & in_range & sample[pos];

  always_ff @(negedge clk) begin
    if (rst) begin
      a_out <= 1'b0;
      b_out <= 1'b0;
    end else begin
      a_out <= decode & drive;
      b_out <= ~decode & drive;
    end
  end

endmodule

// File: rtl/sbd_delay_port.sv
module sbd_delay_port import sbd_pkg::*; #(
  parameter int SAMPLE_W     = 24,
  parameter int HALF_SLOTS   = 32,
  parameter int ENC_DELAY    = 480,
  parameter int DEC_DELAY    = 160,
  parameter int GUARD_FRAMES = 2,
  parameter int SB_W         = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dir,
  input  logic            ws,
  input  logic            fsync,
  input  logic            a_in,
  input  logic            b_in,
  output logic            a_out,
  output logic            a_oe,
  output logic            b_out,
  output logic            b_oe,
  output logic [SB_W-1:0] sb_idx,
  output logic            sb_valid
);

  localparam int WORD_W = 2 * SAMPLE_W;
  localparam int SLOT_W = $clog2(HALF_SLOTS) + 1;
  localparam int GCNT_W = $clog2(GUARD_FRAMES + 1);

  dir_e              dir_q;
  logic              decode;
  logic              rx_bit;
  logic              frame_start;
  logic              word_stb;
  logic [WORD_W-1:0] rx_word;
  logic [WORD_W-1:0] rd_word;
  logic              filled;
  logic [SLOT_W-1:0] next_slot;
  logic              next_right;
  logic [GCNT_W-1:0] gcnt;

  // Direction follows the input only while reset is held.
  always_ff @(posedge clk) begin
    if (rst) dir_q <= dir ? DIR_DECODE : DIR_ENCODE;
  end

  assign decode = (dir_q == DIR_DECODE);
  assign rx_bit = decode ? b_in : a_in;

  sbd_frame_rx #(
    .SAMPLE_W (SAMPLE_W),
    .SLOT_W   (SLOT_W),
    .SB_W     (SB_W)
  ) u_rx (
    .clk         (clk),
    .rst         (rst),
    .ws          (ws),
    .din         (rx_bit),
    .fsync       (fsync),
    .frame_start (frame_start),
    .word_stb    (word_stb),
    .word        (rx_word),
    .next_slot   (next_slot),
    .next_right  (next_right),
    .sb_idx      (sb_idx),
    .sb_valid    (sb_valid)
  );

  sbd_ring #(
    .WORD_W    (WORD_W),
    .ENC_DELAY (ENC_DELAY),
    .DEC_DELAY (DEC_DELAY)
  ) u_ring (
    .clk     (clk),
    .rst     (rst),
    .decode  (decode),
    .wr_stb  (word_stb),
    .wr_word (rx_word),
    .rd_word (rd_word),
    .filled  (filled)
  );

  sbd_tx #(
    .SAMPLE_W (SAMPLE_W),
    .SLOT_W   (SLOT_W)
  ) u_tx (
    .clk        (clk),
    .rst        (rst),
    .decode     (decode),
    .active     (a_oe | b_oe),
    .filled     (filled),
    .word       (rd_word),
    .next_slot  (next_slot),
    .next_right (next_right),
    .a_out      (a_out),
    .b_out      (b_out)
  );

  // Guard interval: enables stay off for GUARD_FRAMES word starts.
  always_ff @(posedge clk) begin
    if (rst) begin
      gcnt <= '0;
      a_oe <= 1'b0;
      b_oe <= 1'b0;
    end else if (frame_start && !(a_oe || b_oe)) begin
      if (gcnt == GCNT_W'(GUARD_FRAMES)) begin
        a_oe <= decode;
        b_oe <= ~decode;
      end else begin
        gcnt <= gcnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sbd_delay_port_chk.sv
module sbd_delay_port_chk #(
  parameter int SB_W = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            fsync,
  input logic            frame_start,
  input logic            decode,
  input logic            filled,
  input logic            a_out,
  input logic            a_oe,
  input logic            b_out,
  input logic            b_oe,
  input logic [SB_W-1:0] sb_idx,
  input logic            sb_valid
);

  // R6
  a_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !a_oe |-> !a_out);

  // R6
  b_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !b_oe |-> !b_out);

  // R6
  oe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (a_oe || b_oe) |=> (a_oe || b_oe));

  // R5
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(decode));

  // R4
  fill_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !filled |-> (!a_out && !b_out));

  // R7
  sb_step_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !fsync && sb_valid) |=> (sb_idx == $past(sb_idx) + 1'b1));

  // R7
  sb_still_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> ($stable(sb_idx) && $stable(sb_valid)));

endmodule

bind sbd_delay_port sbd_delay_port_chk #(.SB_W(SB_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fsync       (fsync),
  .frame_start (frame_start),
  .decode      (decode),
  .filled      (filled),
  .a_out       (a_out),
  .a_oe        (a_oe),
  .b_out       (b_out),
  .b_oe        (b_oe),
  .sb_idx      (sb_idx),
  .sb_valid    (sb_valid)
);

// File: tb/sbd_delay_port_bench.sv
module sbd_delay_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int GUARD      = 2;
  localparam int N_SCN      = 3;

  // Scenario table: stimulus settings and the delay each one must show.
  localparam int SCN_DIR   [N_SCN] = '{0, 1, 1};
  localparam int SCN_PER   [N_SCN] = '{500, 180, 180};
  localparam int SCN_SYNC  [N_SCN] = '{3, 5, 0};
  localparam int SCN_REP   [N_SCN] = '{1, 0, 1};
  localparam int SCN_FLIP  [N_SCN] = '{0, 0, 1};
  localparam int SCN_DELAY [N_SCN] = '{480, 160, 160};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir = 1'b0;
  logic ws = 1'b1;
  logic fsync = 1'b0;
  logic a_in = 1'b0;
  logic b_in = 1'b0;
  logic a_out, a_oe, b_out, b_oe, sb_valid;
  logic [4:0] sb_idx;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbd_delay_port u_sbd_delay_port (
    .clk(clk), .rst(rst), .dir(dir), .ws(ws), .fsync(fsync),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
    .b_out(b_out), .b_oe(b_oe), .sb_idx(sb_idx), .sb_valid(sb_valid)
  );

  function automatic logic [23:0] smp(int p, bit right);
    logic [31:0] x;
    x = 32'(p) * 32'h9E3779B1 + (right ? 32'h5A5A1234 : 32'h0F0F3C3C);
    return x[31:8] ^ {x[7:0], x[31:16]};
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_scn(int d, int per, int p0, int rep, int flip, int dly);
    // reset; for the flip case the input differs early in reset
    rst = 1'b1; ws = 1'b1; fsync = 1'b0; a_in = 1'b0; b_in = 1'b0;
    dir = flip ? ~d[0] : d[0];
    repeat (4) @(negedge clk);
    dir = d[0];
    repeat (2) @(negedge clk);
    #(CLK_PERIOD/4);
    // R8: reset state
    check({a_oe, b_oe, a_out, b_out, sb_valid} == 5'b0, "R8", "reset outputs",
          {a_oe, b_oe, a_out, b_out, sb_valid}, 0);
    @(negedge clk);
    rst = 1'b0;
    for (int p = 0; p < per; p++) begin
      logic [23:0] gl, gr;
      logic [47:0] exp_w;
      bit pad_bad, other_bad;
      pad_bad = 0; other_bad = 0; gl = '0; gr = '0;
      for (int s = 0; s < 64; s++) begin
        int k;
        bit right, bv, o, oo, ooe, sy;
        logic [23:0] cur;
        k = s % 32; right = (s >= 32);
        sy = rep ? (p >= p0 && ((p - p0) % 32) == 0) : (p == p0);
        cur = smp(p, right);
        bv = (k >= 1 && k <= 24) ? cur[24-k] : 1'b0;
        @(negedge clk);
        if (flip && p == 10 && s == 0) dir = ~d[0];
        ws = right; fsync = sy;
        if (d) begin b_in = bv; a_in = ~bv; end
        else   begin a_in = bv; b_in = ~bv; end
        @(posedge clk);
        #(CLK_PERIOD/4);
        o   = d ? a_out : b_out;
        oo  = d ? b_out : a_out;
        ooe = d ? b_oe  : a_oe;
        if (k >= 1 && k <= 24) begin
          if (right) gr[24-k] = o; else gl[24-k] = o;
        end else if (o) pad_bad = 1;
        if (oo || ooe) other_bad = 1;
        if (s == 10) begin
          bit eoe, ev;
          int ei;
          eoe = (p >= GUARD);
          // R6: transmit enable after guard interval
          check((d ? a_oe : b_oe) == eoe, "R6", "tx enable", d ? a_oe : b_oe, eoe);
          ev = (p >= p0);
          ei = ev ? ((p - p0) % 32) : 0;
          // R7: sub-band tracking
          check(sb_valid == ev && (!ev || sb_idx == 5'(ei)), "R7", "sub-band",
                {sb_valid, sb_idx}, {ev, 5'(ei)});
        end
      end
      exp_w = (p >= dly) ? {smp(p - dly, 0), smp(p - dly, 1)} : 48'h0;
      if (p < dly)
        check({gl, gr} == exp_w, "R4", "zero before fill", {gl, gr}, exp_w);
      else if (flip)
        check({gl, gr} == exp_w, "R5", "late dir change ignored", {gl, gr}, exp_w);
      else if (d)
        check({gl, gr} == exp_w, "R3", "decode replay", {gl, gr}, exp_w);
      else
        check({gl, gr} == exp_w, "R2", "encode replay", {gl, gr}, exp_w);
      // R1: unused slots carry zero
      check(!pad_bad, "R1", "pad slots", pad_bad, 0);
      // R5: other pin silent and disabled
      check(!other_bad, "R5", "other pin idle", other_bad, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_err++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < N_SCN; i++)
      run_scn(SCN_DIR[i], SCN_PER[i], SCN_SYNC[i], SCN_REP[i], SCN_FLIP[i], SCN_DELAY[i]);
    // directed: reset mid-stream clears outputs and enables again (R8, R6)
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    check({a_oe, b_oe, a_out, b_out, sb_valid} == 5'b0, "R8", "reset after run",
          {a_oe, b_oe, a_out, b_out, sb_valid}, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule